// File: doc/BRIEF.md
# Decimal Ratio Pulse Divider

This block divides an incoming pulse train by a three-digit decimal ratio N. Each input clock counts as one pulse. The block gives one strobe for every N input clocks. The ratio comes in as three decimal digits on a 12-bit preset bus. Each digit is in nine's-complement form, and a high level means logic 1.

The block holds three decade counters in a chain. The least significant decade advances on every running clock. Each higher decade advances only when every decade below it reads 9. When all three decades read 9, the block has reached terminal count, and on the next clock it reloads a start value derived from the preset. A small state machine has two states:

- `ST_LOAD` is entered on reset. In this state the decades take the start value and terminal count is held off.
- `ST_RUN` is the counting state.

The machine has two transitions:

- `ST_LOAD` to `ST_RUN` happens on the first clock without reset.
- `ST_RUN` to `ST_RUN` happens on every other clock. On a terminal-count clock, this transition also reloads the decades.

With a 4 MHz input and N = 800, the output strobe runs at 5 kHz.

Top module: `bcd_ratio_divider`

## Requirements
- R1: While running, `term_cnt` is high for one clock in every N clocks, where N is the ratio the preset encodes.
- R2: After reset is released, the first `term_cnt` appears in the (N-1)th clock, counting from 0 at the first clock edge after release.
- R3: `div_out` repeats `term_cnt` one clock later, so for N > 1 each `div_out` pulse lasts exactly one clock.
- R4: While reset is held, and in the `ST_LOAD` state, both `term_cnt` and `div_out` stay low.
- R5: A change on `preset` in the middle of a period does not shorten or lengthen that period. The new ratio applies from the next reload onward.
- R6: The preset code with all three digits equal to 1001 means N = 0, and the block then divides by 1000.
- R7: Digit coding is as follows:
  - `preset[11:8]` holds the hundreds digit, `preset[7:4]` the tens digit and `preset[3:0]` the units digit.
  - Each digit field holds 9 minus the decimal digit, with bit weights 8-4-2-1, so 0000 means 9 and 1001 means 0.
- R8: The units decade steps by one on each running clock that is not a reload, and wraps from 9 to 0.
- R9: On the clock after `term_cnt`, the decades hold the complement of N plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input pulse train; each rising edge is one counted pulse |
| rst | input | 1 | Synchronous reset, active high |
| preset | input | 12 | Three nine's-complement BCD digits of the ratio |
| term_cnt | output | 1 | High in the clock where all decades read 9 |
| div_out | output | 1 | Divided output, `term_cnt` delayed by one clock |

## Verification
The assertions assume that every preset digit is a legal BCD code (0 to 9). An input assertion states this assumption, and the decade step and reload checks rely on it. The stimulus builds every preset from decimal ratios by taking 9 minus each digit, so no code above 1001 is ever driven. Preset changes are made only on the falling edge, which keeps the reload check relating the preset of one clock to the decades of the next clock.

// File: rtl/divn_pkg.sv
package divn_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_t;
    localparam bcd_t BCD_MAX = 4'd9;

    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } div_state_t;
endpackage

// File: rtl/divn_decade.sv
module divn_decade
    import divn_pkg::*;
(
    input  logic clk,
    input  logic load,
    input  bcd_t ld_digit,
    input  logic ld_cin,
    output logic ld_cout,
    input  logic step,
    output bcd_t q,
    output logic at_nine
);
    bcd_t ld_sum;

    always_comb begin
        ld_cout = ld_cin && (ld_digit == BCD_MAX);
        if (ld_cout)
            ld_sum = '0;
        else
            ld_sum = ld_digit + bcd_t'(ld_cin);
    end

    assign at_nine = (q == BCD_MAX);

    always_ff @(posedge clk) begin
        if (load)
            q <= ld_sum;
        else if (step)
            q <= at_nine ? bcd_t'(0) : q + bcd_t'(1);
    end
endmodule

// File: rtl/divn_ctrl.sv
module divn_ctrl
    import divn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic all_nine,
    output logic load,
    output logic step,
    output logic term_cnt,
    output logic div_out
);
    div_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_LOAD;
        else
            state_q <= state_d;
    end

    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        term_cnt = 1'b0;
        unique case (state_q)
            ST_LOAD: load = 1'b1;
            ST_RUN: begin
                step     = 1'b1;
                term_cnt = all_nine;
                load     = all_nine;
            end
            default: load = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            div_out <= 1'b0;
        else
            div_out <= term_cnt;
    end

    // R3: the divided output trails terminal count by one clock
    a_r3_out_follows: assert property (@(posedge clk) disable iff (rst)
        term_cnt |=> div_out);
    a_r3_out_clears: assert property (@(posedge clk) disable iff (rst)
        !term_cnt |=> !div_out);
    // R4: no terminal count while priming
    a_r4_quiet_load: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD) |-> !term_cnt);
    // R4: reset forces priming state
    a_r4_reset_primes: assert property (@(posedge clk)
        rst |=> (state_q == ST_LOAD) && !div_out);
endmodule

// File: rtl/bcd_ratio_divider.sv
module bcd_ratio_divider
    import divn_pkg::*;
#(
    parameter int DIGITS = 3,
    localparam int PW = DIGITS * DIGIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] preset,
    output logic          term_cnt,
    output logic          div_out
);
    bcd_t        dq    [DIGITS];
    logic [DIGITS-1:0] nine;
    logic [DIGITS:0]   step_chain;
    logic [DIGITS:0]   ld_chain;
    logic              load, step;
    logic [PW-1:0]     cnt_flat;

    assign step_chain[0] = step;
    assign ld_chain[0]   = 1'b1;

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_dec
            divn_decade u_dec (
                .clk      (clk),
                .load     (load),
                .ld_digit (preset[i*DIGIT_W +: DIGIT_W]),
                .ld_cin   (ld_chain[i]),
                .ld_cout  (ld_chain[i+1]),
                .step     (step_chain[i]),
                .q        (dq[i]),
                .at_nine  (nine[i])
            );
            assign step_chain[i+1] = step_chain[i] & nine[i];
            assign cnt_flat[i*DIGIT_W +: DIGIT_W] = dq[i];

            // R7: preset digits are legal BCD codes
            a_r7_preset_bcd: assert property (@(posedge clk) disable iff (rst)
                preset[i*DIGIT_W +: DIGIT_W] <= BCD_MAX);
            // R8: decades never leave the decimal range once running
            a_r8_digit_range: assert property (@(posedge clk) disable iff (rst)
                step && !load |-> dq[i] <= BCD_MAX);
        end
    endgenerate

    divn_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .all_nine (&nine),
        .load     (load),
        .step     (step),
        .term_cnt (term_cnt),
        .div_out  (div_out)
    );

    // R8: units decade advances by one each running, non-reload clock
    a_r8_units_step: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=>
            dq[0] == (($past(dq[0]) == BCD_MAX) ? bcd_t'(0) : $past(dq[0]) + bcd_t'(1)));
    // R9: after terminal count the decades hold the preset plus one
    a_r9_reload_value: assert property (@(posedge clk) disable iff (rst)
        term_cnt |=> cnt_flat == bcd_plus_one($past(preset)));

    function automatic logic [PW-1:0] bcd_plus_one(input logic [PW-1:0] v);
        logic [PW-1:0] r;
        logic c;
        c = 1'b1;
        for (int k = 0; k < DIGITS; k++) begin
            if (c && v[k*DIGIT_W +: DIGIT_W] == BCD_MAX) begin
                r[k*DIGIT_W +: DIGIT_W] = '0;
            end else begin
                r[k*DIGIT_W +: DIGIT_W] = v[k*DIGIT_W +: DIGIT_W] + bcd_t'(c);
                c = 1'b0;
            end
        end
        return r;
    endfunction
endmodule

// File: tb/bcd_ratio_divider_test.sv
module bcd_ratio_divider_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] preset = 12'h999;
    logic        term_cnt, div_out;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bcd_ratio_divider uut (
        .clk(clk), .rst(rst), .preset(preset),
        .term_cnt(term_cnt), .div_out(div_out)
    );

    localparam int NV = 8;
    localparam int VN   [NV] = '{1, 800, 999, 5, 10, 37, 100, 0};
    localparam int VPER [NV] = '{1, 800, 999, 5, 10, 37, 100, 1000};

    function automatic logic [11:0] encode(input int n);
        int h, t, u;
        h = (n / 100) % 10;
        t = (n / 10) % 10;
        u = n % 10;
        return {4'(9 - h), 4'(9 - t), 4'(9 - u)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [11:0] code);
        @(negedge clk);
        rst = 1'b1;
        preset = code;
        repeat (3) begin
            @(negedge clk);
            check(term_cnt == 1'b0 && div_out == 1'b0, "R4 quiet in reset",
                  int'({term_cnt, div_out}), 0);
        end
        rst = 1'b0;
    endtask

    // Measures first terminal count index and the following period
    task automatic measure(input int per, input string tag);
        int first = -1, second = -1;
        for (int k = 0; k < 2200 && second < 0; k++) begin
            @(negedge clk);
            if (first >= 0 && k == first + 1)
                check(div_out == 1'b1, "R3 div_out follows", int'(div_out), 1);
            if (first >= 0 && k == first + 2 && per > 2)
                check(div_out == 1'b0, "R3 one clock wide", int'(div_out), 0);
            if (term_cnt) begin
                if (first < 0) first = k;
                else second = k;
            end
        end
        check(first == per - 1, {"R2 first strobe ", tag}, first, per - 1);
        check(second - first == per, {"R1 period ", tag}, second - first, per);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R7 coding: table walked with presets built digit by digit (R6 for N=0)
        for (int v = 0; v < NV; v++) begin
            do_reset(encode(VN[v]));
            measure(VPER[v], (VN[v] == 0) ? "R6 N=0" : "R7 table");
        end

        // R5: change preset mid-period, old period must complete
        begin
            int first = -1, second = -1;
            do_reset(encode(800));
            for (int k = 0; k < 900 && second < 0; k++) begin
                @(negedge clk);
                if (k == 100) preset = encode(5);
                if (term_cnt) begin
                    if (first < 0) first = k;
                    else second = k;
                end
            end
            check(first == 799, "R5 period in progress kept", first, 799);
            check(second - first == 5, "R5 new ratio after reload", second - first, 5);
        end

        // R4: reset asserted mid-count silences outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(term_cnt == 1'b0 && div_out == 1'b0, "R4 reset mid-count",
              int'({term_cnt, div_out}), 0);

        // R8: with N=10 strobes are spaced by ten running clocks again
        do_reset(encode(10));
        measure(10, "R8 units wrap");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule